// File: doc/BRIEF.md
# Fixed-Point ALU with Status Flags

This block is the 32-bit fixed-point arithmetic-logic unit of a signal-processing core. Each cycle in which `op_valid` is high, it takes two operands and a 3-bit opcode. On the next clock edge it registers a primary result, an optional secondary result and a flag set. The operations are add, subtract, a dual add/subtract, compare, bitwise AND, bitwise OR, and pass of either operand. The dual operation returns the sum and the difference of the same operand pair in one cycle.

The flag register holds six bits: zero, negative, overflow, carry, floating-point invalid and floating-point-last. The last two are always 0, because every operation here is fixed point. The flags change only on a valid operation and stay unchanged between operations. A compare writes the flags but no result, so a later condition can read them. A combinational condition evaluator turns the stored flags into one branch-condition bit, selected by `cond_sel`. Software can then compute both candidate values with a dual operation, compare, and choose one of them with a condition such as greater-than.

The block has no state machine. Its only state is the result, flag and write-strobe registers, and it moves between two situations only: "idle" (`op_valid` low, everything held) and "issue" (`op_valid` high, registers load on the edge).

Top module: `alu_fx_core`

## Requirements
- R1: After reset, `res_pri`, `res_sec`, `res_wr`, `sec_wr` and all six flags are 0.
- R2: Opcode 0 (ADD) gives `res_pri` = x+y mod 2^32 one clock edge after issue, with `res_wr`=1. Carry is the carry-out of bit 31. Overflow is set when x and y have the same sign and the result sign differs. Adding -1 and +1 gives zero=1, negative=0, overflow=0, carry=1.
- R3: Opcode 1 (SUB) gives `res_pri` = x-y, with `res_wr`=1. Carry is the carry-out of x + ~y + 1, so carry=1 means no borrow. Overflow is set when x and y differ in sign and the result sign differs from x.
- R4: Opcode 2 (DUAL) gives `res_pri` = x+y and `res_sec` = x-y from the same issue, with `res_wr`=1 and `sec_wr`=1. Its flags follow the sum, as in R2.
- R5: Opcode 3 (CMP) sets the flags exactly as SUB would for x-y. It leaves `res_wr`=0, and `res_pri` and `res_sec` keep their values.
- R6: Opcodes 4 (AND), 5 (OR), 6 (pass x) and 7 (pass y) write x&y, x|y, x or y to `res_pri`. They clear overflow and carry.
- R7: For every operation, zero is set exactly when the flagged value (result, or x-y for CMP) is 0, and negative equals bit 31 of that value.
- R8: `flag_finv` and `flag_flt` are 0 at all times.
- R9: A clock edge with `op_valid`=0 leaves the flags, `res_pri` and `res_sec` unchanged, whatever the operand and opcode inputs carry, and drives `res_wr` and `sec_wr` to 0.
- R10: `cond_true` is a combinational function of the stored flags, selected by `cond_sel`: 0 EQ = zero; 1 NE = !zero; 2 GT = !zero && !(neg^ovf); 3 GE = !(neg^ovf); 4 LT = neg^ovf; 5 LE = zero || (neg^ovf); 6 CS = carry; 7 VS = ovf.
- R11: `res_sec` changes only on a DUAL issue. Every other opcode leaves it unchanged and drives `sec_wr` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe for the opcode and operands |
| op_code | input | 3 | Operation select (encoding in R2 to R6) |
| opnd_x | input | 32 | First operand |
| opnd_y | input | 32 | Second operand |
| cond_sel | input | 3 | Condition select (encoding in R10) |
| res_pri | output | 32 | Primary result register |
| res_sec | output | 32 | Secondary (difference) result register |
| res_wr | output | 1 | Primary result written by the previous edge |
| sec_wr | output | 1 | Secondary result written by the previous edge |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_carry | output | 1 | Fixed-point carry flag |
| flag_finv | output | 1 | Floating-point invalid flag (always 0) |
| flag_flt | output | 1 | Last-operation-floating flag (always 0) |
| cond_true | output | 1 | Selected condition evaluated on the stored flags |

## Verification
The hardest situations to reach are the two signed-overflow corners, because they need operands exactly at the edge of the signed range. One is subtracting a positive value from the most negative number. The other is adding one to the most positive number. The stimulus drives 0x80000000 - 1 and 0x7FFFFFFF + 1 directly, so overflow is seen both with and without a borrow.

The compare-then-condition flow also needs care. The stimulus issues compares with x below, equal to and above y. After each one it sweeps all eight condition selects on the held flags. It also checks that the earlier results in `res_pri` and `res_sec` survive the compare.

// File: rtl/alu_fx_pkg.sv
`timescale 1ns/1ps
package alu_fx_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_DUAL  = 3'd2,
        OP_CMP   = 3'd3,
        OP_AND   = 3'd4,
        OP_OR    = 3'd5,
        OP_PASSX = 3'd6,
        OP_PASSY = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GT = 3'd2,
        CC_GE = 3'd3,
        CC_LT = 3'd4,
        CC_LE = 3'd5,
        CC_CS = 3'd6,
        CC_VS = 3'd7
    } cond_e;

    typedef struct packed {
        logic az;   // zero
        logic an;   // negative
        logic av;   // overflow
        logic ac;   // carry
        logic ai;   // float invalid
        logic af;   // float last
    } flags_t;

endpackage

// File: rtl/alu_fx_addsub.sv
`timescale 1ns/1ps
module alu_fx_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         sum_c,
    output logic         sum_v,
    output logic [W-1:0] diff,
    output logic         diff_c,
    output logic         diff_v
);
    localparam int MSB = W - 1;

    logic [W:0] sum_ext;
    logic [W:0] diff_ext;

    // Two independent carry chains so sum and difference share one cycle.
    always_comb begin
        sum_ext  = {1'b0, a} + {1'b0, b};
        diff_ext = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        sum      = sum_ext[MSB:0];
        diff     = diff_ext[MSB:0];
        sum_c    = sum_ext[W];
        diff_c   = diff_ext[W];
        sum_v    = (a[MSB] == b[MSB]) && (sum[MSB]  != a[MSB]);
        diff_v   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_fx_logic.sv
`timescale 1ns/1ps
module alu_fx_logic
    import alu_fx_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_PASSX: res = a;
            default:  res = b;
        endcase
    end

endmodule

// File: rtl/alu_fx_cond.sv
`timescale 1ns/1ps
module alu_fx_cond
    import alu_fx_pkg::*;
(
    input  flags_t fl,
    input  cond_e  sel,
    output logic   hit
);
    logic lt_raw;

    always_comb begin
        lt_raw = fl.an ^ fl.av;
        unique case (sel)
            CC_EQ:   hit = fl.az;
            CC_NE:   hit = !fl.az;
            CC_GT:   hit = !fl.az && !lt_raw;
            CC_GE:   hit = !lt_raw;
            CC_LT:   hit = lt_raw;
            CC_LE:   hit = fl.az || lt_raw;
            CC_CS:   hit = fl.ac;
            default: hit = fl.av;
        endcase
    end

endmodule

// File: rtl/alu_fx_core.sv
`timescale 1ns/1ps
module alu_fx_core
    import alu_fx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_x,
    input  logic [DATA_W-1:0] opnd_y,
    input  logic [2:0]        cond_sel,
    output logic [DATA_W-1:0] res_pri,
    output logic [DATA_W-1:0] res_sec,
    output logic              res_wr,
    output logic              sec_wr,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_ovf,
    output logic              flag_carry,
    output logic              flag_finv,
    output logic              flag_flt,
    output logic              cond_true
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] sum, diff, lres, val;
    logic              sum_c, sum_v, diff_c, diff_v;
    logic              wr_p, wr_s;
    flags_t            nxt_fl, flag_q;
    logic [DATA_W-1:0] pri_q, sec_q;
    logic              res_wr_q, sec_wr_q;

    assign op = alu_op_e'(op_code);

    alu_fx_addsub #(.W(DATA_W)) u_addsub (
        .a(opnd_x), .b(opnd_y),
        .sum(sum), .sum_c(sum_c), .sum_v(sum_v),
        .diff(diff), .diff_c(diff_c), .diff_v(diff_v)
    );

    alu_fx_logic #(.W(DATA_W)) u_logic (
        .op(op), .a(opnd_x), .b(opnd_y), .res(lres)
    );

    alu_fx_cond u_cond (
        .fl(flag_q), .sel(cond_e'(cond_sel)), .hit(cond_true)
    );

    // Next-value selection
    always_comb begin
        nxt_fl = '0;
        wr_p   = 1'b1;
        wr_s   = 1'b0;
        val    = lres;
        unique case (op)
            OP_ADD: begin
                val       = sum;
                nxt_fl.ac = sum_c;
                nxt_fl.av = sum_v;
            end
            OP_SUB: begin
                val       = diff;
                nxt_fl.ac = diff_c;
                nxt_fl.av = diff_v;
            end
            OP_DUAL: begin
                val       = sum;
                nxt_fl.ac = sum_c;
                nxt_fl.av = sum_v;
                wr_s      = 1'b1;
            end
            OP_CMP: begin
                val       = diff;
                nxt_fl.ac = diff_c;
                nxt_fl.av = diff_v;
                wr_p      = 1'b0;
            end
            default: begin
                val       = lres;
                nxt_fl.ac = 1'b0;
                nxt_fl.av = 1'b0;
            end
        endcase
        nxt_fl.az = (val == '0);
        nxt_fl.an = val[MSB];
        nxt_fl.ai = 1'b0;
        nxt_fl.af = 1'b0;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= '0;
            pri_q    <= '0;
            sec_q    <= '0;
            res_wr_q <= 1'b0;
            sec_wr_q <= 1'b0;
        end else begin
            res_wr_q <= op_valid && wr_p;
            sec_wr_q <= op_valid && wr_s;
            if (op_valid) begin
                flag_q <= nxt_fl;
                if (wr_p) pri_q <= val;
                if (wr_s) sec_q <= diff;
            end
        end
    end

    assign res_pri    = pri_q;
    assign res_sec    = sec_q;
    assign res_wr     = res_wr_q;
    assign sec_wr     = sec_wr_q;
    assign flag_zero  = flag_q.az;
    assign flag_neg   = flag_q.an;
    assign flag_ovf   = flag_q.av;
    assign flag_carry = flag_q.ac;
    assign flag_finv  = flag_q.ai;
    assign flag_flt   = flag_q.af;

    // Assertions
    p_fp_flags_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_finv && !flag_flt));

    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |=> (!res_wr && $stable(res_pri) && $stable(res_sec)));

    p_dual_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |=> (sec_wr && ((res_pri - res_sec) == ($past(opnd_y) << 1))));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> ($stable(flag_q) && $stable(res_pri) && !res_wr && !sec_wr));

    p_logic_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[2]) |=> (!flag_carry && !flag_ovf));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> (flag_zero == (res_pri == '0)));

    p_sec_only_dual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 3'd2) |=> $stable(res_sec));

    p_gt_not_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd2 && cond_true) |-> !flag_zero);

endmodule

// File: tb/alu_fx_core_tb.sv
`timescale 1ns/1ps
module alu_fx_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] opnd_x = '0, opnd_y = '0;
    logic [2:0]  cond_sel = 3'd0;
    logic [31:0] res_pri, res_sec;
    logic        res_wr, sec_wr;
    logic        flag_zero, flag_neg, flag_ovf, flag_carry, flag_finv, flag_flt;
    logic        cond_true;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    logic [31:0] e_pri = '0, e_sec = '0;
    logic        e_wr = 0, e_swr = 0, e_z = 0, e_n = 0, e_v = 0, e_c = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu_fx_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_x(opnd_x), .opnd_y(opnd_y), .cond_sel(cond_sel),
        .res_pri(res_pri), .res_sec(res_sec), .res_wr(res_wr), .sec_wr(sec_wr),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
        .flag_carry(flag_carry), .flag_finv(flag_finv), .flag_flt(flag_flt),
        .cond_true(cond_true)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected behaviour derived from R2..R7, R11
    task automatic model(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        logic [32:0] e;
        logic [31:0] r;
        r = '0;
        case (op)
            3'd0, 3'd2: begin
                e = {1'b0, x} + {1'b0, y}; r = e[31:0]; e_c = e[32];
                e_v = (x[31] == y[31]) && (r[31] != x[31]);
            end
            3'd1, 3'd3: begin
                e = {1'b0, x} + {1'b0, ~y} + 33'd1; r = e[31:0]; e_c = e[32];
                e_v = (x[31] != y[31]) && (r[31] != x[31]);
            end
            default: begin
                case (op)
                    3'd4: r = x & y;
                    3'd5: r = x | y;
                    3'd6: r = x;
                    default: r = y;
                endcase
                e_c = 0; e_v = 0;
            end
        endcase
        e_z = (r == 0);
        e_n = r[31];
        e_wr = (op != 3'd3);
        e_swr = (op == 3'd2);
        if (op != 3'd3) e_pri = r;
        if (op == 3'd2) e_sec = x - y;
    endtask

    function automatic logic cond_exp(input logic [2:0] s);
        case (s)
            3'd0: return e_z;
            3'd1: return !e_z;
            3'd2: return !e_z && !(e_n ^ e_v);
            3'd3: return !(e_n ^ e_v);
            3'd4: return e_n ^ e_v;
            3'd5: return e_z || (e_n ^ e_v);
            3'd6: return e_c;
            default: return e_v;
        endcase
    endfunction

    task automatic check_all(input string req);
        chk(req, "res_pri", res_pri, e_pri);
        chk(req, "res_sec", res_sec, e_sec);
        chk(req, "flags", {26'd0, flag_zero, flag_neg, flag_ovf, flag_carry, flag_finv, flag_flt},
            {26'd0, e_z, e_n, e_v, e_c, 2'b00});
        chk(req, "strobes", {30'd0, res_wr, sec_wr}, {30'd0, e_wr, e_swr});
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        op_valid = 1; op_code = op; opnd_x = x; opnd_y = y;
        @(negedge clk);
        op_valid = 0;
        model(op, x, y);
    endtask

    task automatic sweep_cond(input string req);
        for (int s = 0; s < 8; s++) begin
            cond_sel = s[2:0];
            #1;
            chk(req, $sformatf("cond %0d", s), {31'd0, cond_true}, {31'd0, cond_exp(s[2:0])});
        end
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_add;
        run_op(3'd0, 32'hFFFF_FFFF, 32'd1);            // -1 + 1
        check_all("R2");
        chk("R7", "zero on -1+1", {31'd0, flag_zero}, 32'd1);
        run_op(3'd0, 32'h7FFF_FFFF, 32'd1);            // overflow, no carry
        check_all("R2");
        run_op(3'd0, 32'h1234_0000, 32'h0000_5678);
        check_all("R2");
    endtask

    task automatic t_sub;
        run_op(3'd1, 32'd5, 32'd7);                    // borrow
        check_all("R3");
        run_op(3'd1, 32'h8000_0000, 32'd1);            // overflow, no borrow
        check_all("R3");
        run_op(3'd1, 32'd9, 32'd9);
        check_all("R7");
    endtask

    task automatic t_dual;
        run_op(3'd2, 32'd100, 32'd30);
        check_all("R4");
        run_op(3'd2, 32'hFFFF_FFF0, 32'h0000_0020);
        check_all("R4");
    endtask

    task automatic t_cmp;
        run_op(3'd3, 32'd3, 32'd9);
        check_all("R5");
        sweep_cond("R10");
        run_op(3'd3, 32'd9, 32'd3);
        check_all("R5");
        sweep_cond("R10");
        run_op(3'd3, 32'hFFFF_FFFB, 32'hFFFF_FFFB);
        check_all("R5");
        sweep_cond("R10");
        run_op(3'd3, 32'h8000_0000, 32'd1);            // signed LT via overflow
        sweep_cond("R10");
    endtask

    task automatic t_logic;
        run_op(3'd0, 32'h7FFF_FFFF, 32'd1);            // set overflow first
        run_op(3'd4, 32'hF0F0_1234, 32'h0FF0_FF00);
        check_all("R6");
        run_op(3'd5, 32'h8000_0000, 32'h0000_0001);
        check_all("R6");
        run_op(3'd6, 32'h0000_0000, 32'h5555_5555);
        check_all("R6");
        run_op(3'd7, 32'h0000_0000, 32'hAAAA_0000);
        check_all("R11");
    endtask

    task automatic t_hold;
        run_op(3'd1, 32'd5, 32'd7);
        @(negedge clk);
        op_code = 3'd0; opnd_x = 32'hFFFF_FFFF; opnd_y = 32'd1;   // ignored
        @(negedge clk);
        e_wr = 0; e_swr = 0;
        check_all("R9");
        chk("R8", "fp flags", {30'd0, flag_finv, flag_flt}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_add;
        t_sub;
        t_dual;
        t_cmp;
        t_logic;
        t_hold;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule